// File: doc/BRIEF.md
# Vectored Interrupt Controller with Acknowledge Pulse Mode

This block gathers a set of level-sensitive interrupt lines and drives a single master interrupt line toward a host processor. The host talks to it through a simple word-addressed register bus. Through that bus the host can:

- read the live state of the inputs;
- set and clear per-source enable bits, and read them back;
- raise any source from software;
- fill a small table that holds one vector word per source.

While an interrupt is being serviced, the host reads the table entry of the selected source from the vector register. It then writes anything to the acknowledge register. After that the controller either picks the next pending source or lets the master line go inactive.

The master line's active level is programmable. Some hosts only sense edges. For them, an acknowledge-pulse mode holds the line inactive for a programmed number of clock cycles after each acknowledge, so that a following request always shows up as a fresh edge.

The bus has no back-pressure. A write is taken on any clock edge where `bus_wr` is high. A read is taken on any clock edge where `bus_rd` is high. `bus_rdata` is valid, with `bus_rvalid` high, for the one cycle after that edge.

Top module: `virq_ctrl`

## Requirements
- R1: After reset the control word, the enable bits, the software requests and every table entry are 0. The master line is therefore inactive, which with polarity 0 means it reads 1.
- R2: Reading word 1 returns the current level of `irq_in` in bits N-1:0.
- R3: A write to word 2 sets each enable bit written as 1. A write to word 3 clears each enable bit written as 1. Bits written as 0 leave their enable bit unchanged. Word 4 reads back the enable bits.
- R4: A source is pending when its input or its software request is high and its enable bit is set. When nothing is in service and the controller is enabled, the lowest-numbered pending source is taken into service on the next clock edge, and the master line goes active after that edge.
- R5: The source in service does not change until it is acknowledged, even if a lower-numbered source becomes pending or its own input drops. Word 5 reads the table entry of the source in service, or 0 when no source is in service.
- R6: Any write to word 7 acknowledges the source in service. The master line goes inactive after that edge, and the next pending source is taken on the following edge. A write to word 7 with no source in service has no effect.
- R7: Writing 1 to bit i of word 6 raises a software request for source i. The request stays set, even while the source is disabled, until source i is acknowledged.
- R8: Control bit 0 enables the controller. While it is 0, the master line is inactive and no new source is taken into service.
- R9: Control bit 1 sets the polarity of the master line: 1 makes it active high, 0 makes it active low.
- R10: Control bit 2 turns on acknowledge-pulse mode, and control bits 18:3 hold a length L. In this mode with L > 0, a still-pending source drives the master line inactive for L+1 cycles after an acknowledge. When L = 0, the line is inactive for one cycle after an acknowledge, the same as with the mode off.
- R11: Words 8 to 8+N-1 hold the vector table. Each word is writable and reads back the value written.
- R12: A read returns its data with `bus_rvalid` high one cycle after `bus_rd`. Reads of the write-only words 2, 3, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N | Level interrupt inputs, active high |
| bus_addr | input | AW | Word address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| irq_master | output | 1 | Master interrupt line to the host |

## Verification
Selection is tried with several sources raised together, with a lower source arriving while a higher one is in service, and with inputs dropping during service. Together these separate lowest-first priority from a frozen selection and from re-evaluation at acknowledge. Software requests are raised on enabled and on disabled sources, which shows that a request is held until it is acknowledged and is gated by the enable bit. The master line is traced cycle by cycle after acknowledges with the pulse mode off, on with L=3, and on with L=0. This tells the programmed hold-off apart from the single idle cycle every acknowledge already gives, and both polarities and the global enable are covered.

// File: rtl/virq_pkg.sv
package virq_pkg;
  localparam int DW      = 32;
  localparam int LEN_W   = 16;
  localparam int LEN_LSB = 3;

  localparam int W_CTL = 0;
  localparam int W_RAW = 1;
  localparam int W_ENA = 2;
  localparam int W_DIS = 3;
  localparam int W_MSK = 4;
  localparam int W_VEC = 5;
  localparam int W_SWI = 6;
  localparam int W_EOI = 7;
  localparam int W_TBL = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SERVE = 2'd1,
    ST_HOLD  = 2'd2
  } seq_st_t;
endpackage

// File: rtl/virq_prio.sv
module virq_prio #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/virq_seq.sv
module virq_seq
  import virq_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             emu,
  input  logic [LEN_W-1:0] len,
  input  logic [N-1:0]     pend,
  input  logic             ack_wr,
  output logic             in_service,
  output logic [IW-1:0]    cur_idx
);
  seq_st_t          st_q;
  logic [LEN_W-1:0] cnt_q;
  logic             any;
  logic [IW-1:0]    win;

  virq_prio #(.N(N), .IW(IW)) u_prio (
    .req (pend),
    .any (any),
    .idx (win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      cur_idx <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (en && any) begin
            st_q    <= ST_SERVE;
            cur_idx <= win;
          end
        end
        ST_SERVE: begin
          if (ack_wr) begin
            if (emu && len != '0) begin
              st_q  <= ST_HOLD;
              cnt_q <= len;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        ST_HOLD: begin
          if (cnt_q <= LEN_W'(1)) st_q <= ST_IDLE;
          else cnt_q <= cnt_q - LEN_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_service = (st_q == ST_SERVE);

  AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && en && |pend) |=> in_service); // R4
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service && !ack_wr) |=> (in_service && $stable(cur_idx))); // R5
  AST_PULSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service && ack_wr && emu && len != '0) |=> !in_service); // R10
endmodule

// File: rtl/virq_regs.sv
module virq_regs
  import virq_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int AW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irq_in,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             bus_rd,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_rvalid,
  input  logic             in_service,
  input  logic [IW-1:0]    cur_idx,
  output logic             en,
  output logic             pol,
  output logic             emu,
  output logic [LEN_W-1:0] len,
  output logic [N-1:0]     pend,
  output logic             ack_wr
);
  localparam int CTL_W = LEN_LSB + LEN_W;

  logic [CTL_W-1:0] ctl_q;
  logic [N-1:0]     mask_q, swi_q, swi_clr;
  logic [DW-1:0]    tbl_q [N];
  logic [DW-1:0]    rd_mux;

  function automatic logic hit(input logic [AW-1:0] a, input int w);
    return a == AW'(w);
  endfunction

  assign en     = ctl_q[0];
  assign pol    = ctl_q[1];
  assign emu    = ctl_q[2];
  assign len    = ctl_q[LEN_LSB +: LEN_W];
  assign ack_wr = bus_wr && hit(bus_addr, W_EOI);
  assign pend   = (irq_in | swi_q) & mask_q;

  always_comb begin
    swi_clr = '0;
    if (ack_wr && in_service) swi_clr[cur_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      mask_q <= '0;
      swi_q  <= '0;
    end else begin
      if (bus_wr && hit(bus_addr, W_CTL)) ctl_q <= bus_wdata[CTL_W-1:0];
      if (bus_wr && hit(bus_addr, W_ENA)) mask_q <= mask_q | bus_wdata[N-1:0];
      if (bus_wr && hit(bus_addr, W_DIS)) mask_q <= mask_q & ~bus_wdata[N-1:0];
      if (bus_wr && hit(bus_addr, W_SWI)) swi_q <= swi_q | bus_wdata[N-1:0];
      else swi_q <= swi_q & ~swi_clr;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_tbl
    always_ff @(posedge clk) begin
      if (!rst_n) tbl_q[g] <= '0;
      else if (bus_wr && hit(bus_addr, W_TBL + g)) tbl_q[g] <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit(bus_addr, W_CTL)) rd_mux = DW'(ctl_q);
    if (hit(bus_addr, W_RAW)) rd_mux = DW'(irq_in);
    if (hit(bus_addr, W_MSK)) rd_mux = DW'(mask_q);
    if (hit(bus_addr, W_VEC) && in_service) rd_mux = tbl_q[cur_idx];
    for (int i = 0; i < N; i++) begin
      if (hit(bus_addr, W_TBL + i)) rd_mux = tbl_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  AST_ENA_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit(bus_addr, W_ENA)) |=>
      ((mask_q & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0]))); // R3
  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit(bus_addr, W_DIS)) |=>
      ((mask_q & $past(bus_wdata[N-1:0])) == '0)); // R3
  AST_SWI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit(bus_addr, W_SWI)) |=>
      ((swi_q & $past(bus_wdata[N-1:0])) == $past(bus_wdata[N-1:0]))); // R7
  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R12
endmodule

// File: rtl/virq_ctrl.sv
module virq_ctrl
  import virq_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1,
  parameter int AW = $clog2(W_TBL + N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_rd,
  output logic [31:0]   bus_rdata,
  output logic          bus_rvalid,
  output logic          irq_master
);
  logic             en, pol, emu, ack_wr, in_service;
  logic [LEN_W-1:0] len;
  logic [N-1:0]     pend;
  logic [IW-1:0]    cur_idx;

  virq_regs #(.N(N), .IW(IW), .AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .in_service (in_service),
    .cur_idx    (cur_idx),
    .en         (en),
    .pol        (pol),
    .emu        (emu),
    .len        (len),
    .pend       (pend),
    .ack_wr     (ack_wr)
  );

  virq_seq #(.N(N), .IW(IW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .emu        (emu),
    .len        (len),
    .pend       (pend),
    .ack_wr     (ack_wr),
    .in_service (in_service),
    .cur_idx    (cur_idx)
  );

  assign irq_master = (en && in_service) ? pol : !pol;

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!en || !in_service || $past(in_service)));  // R8
endmodule

// File: tb/virq_ctrl_tb.sv
module virq_ctrl_tb;
  localparam int N  = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic          irq_master;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  virq_ctrl #(.N(N)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .irq_master (irq_master)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_addr = AW'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    logic [31:0] d; logic v;
    rd(a, d, v);
    chk(req, {31'd0, v}, 32'd1);
    chk(req, d, exp);
  endtask

  task automatic set_irq(input logic [N-1:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 idle line", {31'd0, irq_master}, 32'd1);
    rd_chk("R1 ctl", 0, 32'd0);
    rd_chk("R1 mask", 4, 32'd0);
    rd_chk("R1 vec", 5, 32'd0);
    rd_chk("R1 tbl", 8, 32'd0);
  endtask

  task automatic t_regs;
    wr(2, 32'hA5);
    rd_chk("R3 enable", 4, 32'hA5);
    wr(3, 32'h05);
    rd_chk("R3 disable", 4, 32'hA0);
    wr(2, 32'h00);
    wr(3, 32'h00);
    rd_chk("R3 zero no effect", 4, 32'hA0);
    rd_chk("R12 write-only reads 0", 2, 32'd0);
    rd_chk("R12 eoi reads 0", 7, 32'd0);
    for (int i = 0; i < N; i++) wr(8 + i, 32'h1000 + i * 4);
    for (int i = 0; i < N; i++) rd_chk("R11 table", 8 + i, 32'h1000 + i * 4);
    set_irq(8'h3C);
    rd_chk("R2 raw", 1, 32'h3C);
    set_irq(8'h00);
    rd_chk("R2 raw low", 1, 32'h00);
    wr(2, 32'hFF);
  endtask

  task automatic t_prio;
    wr(0, 32'h3);
    chk("R9 idle high-pol", {31'd0, irq_master}, 32'd0);
    set_irq(8'h28);
    step();
    chk("R4 asserted", {31'd0, irq_master}, 32'd1);
    rd_chk("R4 lowest", 5, 32'h100C);
    set_irq(8'h2A);
    step();
    rd_chk("R5 frozen", 5, 32'h100C);
    wr(7, 32'd0);
    chk("R6 ack drops", {31'd0, irq_master}, 32'd0);
    step();
    chk("R6 next taken", {31'd0, irq_master}, 32'd1);
    rd_chk("R6 next vec", 5, 32'h1004);
    set_irq(8'h28);
    wr(7, 32'd0);
    step();
    rd_chk("R6 third vec", 5, 32'h100C);
    set_irq(8'h00);
    step();
    rd_chk("R5 kept after drop", 5, 32'h100C);
    wr(7, 32'd0);
    step();
    chk("R6 released", {31'd0, irq_master}, 32'd0);
    rd_chk("R5 none vec", 5, 32'd0);
    wr(7, 32'd0);
    step();
    chk("R6 stray ack ignored", {31'd0, irq_master}, 32'd0);
  endtask

  task automatic t_swi;
    wr(3, 32'h80);
    wr(6, 32'h40);
    step();
    chk("R7 swi raised", {31'd0, irq_master}, 32'd1);
    rd_chk("R7 swi vec", 5, 32'h1018);
    wr(6, 32'h80);
    wr(7, 32'd0);
    step(); step();
    chk("R7 masked swi quiet", {31'd0, irq_master}, 32'd0);
    wr(2, 32'h80);
    step();
    chk("R7 held swi fires", {31'd0, irq_master}, 32'd1);
    rd_chk("R7 held vec", 5, 32'h101C);
    wr(7, 32'd0);
    step(); step();
    chk("R7 cleared by ack", {31'd0, irq_master}, 32'd0);
  endtask

  task automatic t_enable;
    wr(0, 32'h2);
    set_irq(8'h04);
    step(); step();
    chk("R8 disabled quiet", {31'd0, irq_master}, 32'd0);
    rd_chk("R8 no selection", 5, 32'd0);
    wr(0, 32'h3);
    step();
    chk("R8 enabled fires", {31'd0, irq_master}, 32'd1);
    wr(0, 32'h2);
    chk("R8 disable in service", {31'd0, irq_master}, 32'd0);
    wr(0, 32'h1);
    chk("R9 active low", {31'd0, irq_master}, 32'd0);
    set_irq(8'h00);
    wr(7, 32'd0);
    step();
    chk("R9 inactive low-pol", {31'd0, irq_master}, 32'd1);
  endtask

  task automatic t_emu;
    wr(0, 32'h7 | (32'd3 << 3));
    set_irq(8'h01);
    step();
    chk("R10 asserted", {31'd0, irq_master}, 32'd1);
    wr(7, 32'd0);
    chk("R10 hold 0", {31'd0, irq_master}, 32'd0);
    for (int k = 1; k <= 3; k++) begin
      step();
      chk("R10 hold", {31'd0, irq_master}, 32'd0);
    end
    step();
    chk("R10 reassert after L+1", {31'd0, irq_master}, 32'd1);
    wr(0, 32'h7);
    wr(7, 32'd0);
    chk("R10 L0 one cycle", {31'd0, irq_master}, 32'd0);
    step();
    chk("R10 L0 reassert", {31'd0, irq_master}, 32'd1);
    set_irq(8'h00);
    wr(7, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_prio();
    t_swi();
    t_enable();
    t_emu();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule